// File: doc/BRIEF.md
# Daisy-Chainable Serial Result Shifter

This block is the serial readout port of a two-channel converter. Each channel delivers a signed raw result on a parallel input. When the active-low data-ready line falls, both results are offset-coded into 20-bit straight binary and captured in one 40-bit shift register. A host then pulls the transmit-enable line low and toggles the data clock. Each rising data-clock edge moves the register one place toward the serial output, most significant bit first, channel 0 before channel 1.

The serial input is shifted in behind the local bits. This lets several units be wired output-to-input so that one host line collects every result in a single stream. The data clock and the conversion-start line are sampled on the master clock. A guard monitor pulses a flag when the data clock moves too close to a conversion-start transition, on either side of it.

Top module: `ser_result_shifter`

## Requirements
- R1: While reset is asserted, and afterwards until the first capture, the serial output is 0 and the guard flag is 0, even with transmit enabled.
- R2: The output code is raw + 4096, so raw 0 gives 0x01000 and raw +1 gives 0x01001. Any raw value at or below -4096 clips to 0x00000.
- R3: Any raw value at or above 0xFEFFF clips to 0xFFFFF. Raw 0xFEFFE gives 0xFFFFE.
- R4: Capture happens only on a falling edge of `ready_ni`. A steady low level or a rising edge leaves the register unchanged, even if the raw inputs change.
- R5: Right after capture and with transmit enabled, the output shows bit 19 of channel 0. Each rising `dclk_i` edge advances one bit, giving channel 0 bits 19..0 and then channel 1 bits 19..0.
- R6: While `xmit_ni` is high the output is 0, and rising `dclk_i` edges do not shift the register.
- R7: `din_i` is sampled on every shifting edge. The bit sampled on shift k appears on the output after shift k+39, so it follows the 40 local bits.
- R8: If `conv_i` changes within `GUARD_CYC` master cycles after a `dclk_i` transition, `guard_flag_o` pulses high for one cycle.
- R9: If `dclk_i` changes within `GUARD_CYC` master cycles after a `conv_i` transition, `guard_flag_o` pulses high for one cycle. Transitions further apart raise no flag.
- R10: Falling `dclk_i` edges never shift the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| raw_i | input | N_CH*RAW_W (42) | Signed raw results; channel 0 in the lowest slice |
| ready_ni | input | 1 | Data-ready, active low; falling edge captures |
| xmit_ni | input | 1 | Transmit enable, active low |
| dclk_i | input | 1 | Serial data clock, sampled on clk_i |
| din_i | input | 1 | Serial input from the upstream unit |
| conv_i | input | 1 | Conversion-start line watched by the guard |
| dout_o | output | 1 | Serial output |
| guard_flag_o | output | 1 | One-cycle pulse on a guard-window violation |

## Verification
The embedded assertions check the following on every cycle:
- a capture holds exactly the presented word;
- a shift pulls the serial input into the low bit;
- the register stays frozen when neither a capture nor a shift occurs;
- the output is idle while transmit is disabled;
- every flag pulse follows a transition on one of the watched lines.

Only the bench scenarios can show the rest:
- the offset and clipping codes;
- the bit order across both channels and the chained input;
- rejection of a rising or steady-low data-ready;
- whether a given spacing between the two lines falls inside or outside the guard window.

// File: rtl/ser_shift_pkg.sv
package ser_shift_pkg;
  localparam int CODE_W_DEF = 20;
  localparam int RAW_W_DEF  = 21;
  localparam int OFFSET_DEF = 4096;
  localparam int N_CH_DEF   = 2;
  localparam int GUARD_DEF  = 1000;
endpackage

// File: rtl/offset_coder.sv
module offset_coder #(
  parameter int RAW_W  = 21,
  parameter int CODE_W = 20,
  parameter int OFFSET = 4096
) (
  input  logic [RAW_W-1:0]  raw_i,
  output logic [CODE_W-1:0] code_o
);
  localparam int SUM_W = RAW_W + 2;
  localparam logic signed [SUM_W-1:0] OFS  = SUM_W'(OFFSET);
  localparam logic signed [SUM_W-1:0] MAXV = SUM_W'((64'd1 << CODE_W) - 64'd1);

  logic signed [SUM_W-1:0] sum;

  always_comb begin
    sum = $signed({{2{raw_i[RAW_W-1]}}, raw_i}) + OFS;
    if (sum < 0)         code_o = '0;
    else if (sum > MAXV) code_o = '1;
    else                 code_o = sum[CODE_W-1:0];
  end
endmodule

// File: rtl/shift_chain.sv
module shift_chain #(
  parameter int LEN = 40
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic [LEN-1:0] load_word_i,
  input  logic           shift_i,
  input  logic           din_i,
  output logic           msb_o
);
  logic [LEN-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (load_i)  sr_q <= load_word_i;
    else if (shift_i) sr_q <= {sr_q[LEN-2:0], din_i};
  end

  assign msb_o = sr_q[LEN-1];

  assert_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> sr_q == $past(load_word_i));
  assert_shift_in_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && !load_i) |=> sr_q[0] == $past(din_i));
  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!shift_i && !load_i) |=> $stable(sr_q));
endmodule

// File: rtl/guard_monitor.sv
module guard_monitor #(
  parameter int GUARD_CYC = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dclk_tog_i,
  input  logic conv_tog_i,
  output logic flag_o
);
  localparam int CNT_W = $clog2(GUARD_CYC + 1);
  localparam logic [CNT_W-1:0] SAT = CNT_W'(GUARD_CYC);

  logic [CNT_W-1:0] since_dclk_q, since_conv_q;
  logic             viol;

  // counters saturate at the window size; reset means "no recent event"
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_dclk_q <= SAT;
      since_conv_q <= SAT;
    end else begin
      if (dclk_tog_i)               since_dclk_q <= '0;
      else if (since_dclk_q != SAT) since_dclk_q <= since_dclk_q + 1'b1;
      if (conv_tog_i)               since_conv_q <= '0;
      else if (since_conv_q != SAT) since_conv_q <= since_conv_q + 1'b1;
    end
  end

  always_comb begin
    viol = 1'b0;
    if (conv_tog_i && (dclk_tog_i || since_dclk_q < SAT)) viol = 1'b1;
    if (dclk_tog_i && since_conv_q < SAT)                 viol = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_o <= 1'b0;
    else         flag_o <= viol;
  end

  assert_flag_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_o |-> ($past(dclk_tog_i) || $past(conv_tog_i)));
endmodule

// File: rtl/ser_result_shifter.sv
module ser_result_shifter
  import ser_shift_pkg::*;
#(
  parameter int RAW_W     = RAW_W_DEF,
  parameter int CODE_W    = CODE_W_DEF,
  parameter int OFFSET    = OFFSET_DEF,
  parameter int N_CH      = N_CH_DEF,
  parameter int GUARD_CYC = GUARD_DEF
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [N_CH*RAW_W-1:0] raw_i,
  input  logic                  ready_ni,
  input  logic                  xmit_ni,
  input  logic                  dclk_i,
  input  logic                  din_i,
  input  logic                  conv_i,
  output logic                  dout_o,
  output logic                  guard_flag_o
);
  localparam int LEN = N_CH * CODE_W;

  logic           rdy_q, dclk_q, conv_q;
  logic           load, shift, dclk_tog, conv_tog, msb;
  logic [LEN-1:0] load_word;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdy_q  <= 1'b1;
      dclk_q <= 1'b0;
      conv_q <= 1'b0;
    end else begin
      rdy_q  <= ready_ni;
      dclk_q <= dclk_i;
      conv_q <= conv_i;
    end
  end

  assign load     = rdy_q & ~ready_ni;
  assign dclk_tog = dclk_i ^ dclk_q;
  assign conv_tog = conv_i ^ conv_q;
  assign shift    = dclk_i & ~dclk_q & ~xmit_ni;

  // channel 0 occupies the top of the word so it leaves first
  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    offset_coder #(.RAW_W(RAW_W), .CODE_W(CODE_W), .OFFSET(OFFSET)) u_coder (
      .raw_i  (raw_i[c*RAW_W +: RAW_W]),
      .code_o (load_word[LEN-1-c*CODE_W -: CODE_W])
    );
  end

  shift_chain #(.LEN(LEN)) u_chain (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .load_word_i (load_word),
    .shift_i     (shift),
    .din_i       (din_i),
    .msb_o       (msb)
  );

  guard_monitor #(.GUARD_CYC(GUARD_CYC)) u_guard (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .dclk_tog_i (dclk_tog),
    .conv_tog_i (conv_tog),
    .flag_o     (guard_flag_o)
  );

  assign dout_o = ~xmit_ni & msb;

  assert_idle_out_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xmit_ni |-> !dout_o);
endmodule

// File: tb/ser_result_shifter_tb_top.sv
module ser_result_shifter_tb_top;
  localparam int RAW_W = 21, CODE_W = 20, N_CH = 2, GUARD = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic                  rst_n = 1'b0;
  logic [N_CH*RAW_W-1:0] raw = '0;
  logic ready_n = 1'b1, xmit_n = 1'b1, dclk = 1'b0, din = 1'b0, conv = 1'b0;
  logic dout, flag;

  ser_result_shifter #(.RAW_W(RAW_W), .CODE_W(CODE_W), .OFFSET(4096),
                       .N_CH(N_CH), .GUARD_CYC(GUARD)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .raw_i(raw), .ready_ni(ready_n),
    .xmit_ni(xmit_n), .dclk_i(dclk), .din_i(din), .conv_i(conv),
    .dout_o(dout), .guard_flag_o(flag)
  );

  int checks = 0, errors = 0;
  bit    exp_q[$];
  string tag_q[$];
  event  bit_ready;

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [CODE_W-1:0] exp_code(int r);
    int v = r + 4096;
    if (v < 0)       return '0;
    if (v > 1048575) return 20'hFFFFF;
    return v[CODE_W-1:0];
  endfunction

  task automatic push_word(logic [CODE_W-1:0] c, string tag);
    for (int i = CODE_W-1; i >= 0; i--) begin
      exp_q.push_back(c[i]);
      tag_q.push_back(tag);
    end
  endtask

  // monitor: scoreboard pop and compare
  initial begin : mon
    bit e;
    string t;
    forever begin
      @(bit_ready);
      if (exp_q.size() == 0) check(1'b0, "R5", "queue underflow", 0, 0);
      else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(dout == e, t, "dout bit", dout, e);
      end
    end
  end

  // rising edge shifts (R5); the falling half must not shift (R10)
  task automatic pulse_dclk(bit d);
    din  = d;
    dclk = 1'b1;
    @(negedge clk);
    dclk = 1'b0;
    @(negedge clk);
  endtask

  task automatic transfer(int ra, int rb, logic [7:0] dp, string tag,
                          bit disturb, bit pause);
    push_word(exp_code(ra), tag);
    push_word(exp_code(rb), tag);
    for (int i = 7; i >= 0; i--) begin
      exp_q.push_back(dp[i]);
      tag_q.push_back("R7");
    end
    raw = {rb[RAW_W-1:0], ra[RAW_W-1:0]};
    ready_n = 1'b0;
    @(negedge clk);
    if (disturb) raw = {21'h0AAAA, 21'h15555}; // R4: steady low, no reload
    repeat (2) @(negedge clk);
    ready_n = 1'b1;                           // R4: rising edge, no reload
    @(negedge clk);
    xmit_n = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 48; i++) begin
      -> bit_ready;
      #1;
      if (pause && i == 10) begin
        xmit_n = 1'b1;
        @(negedge clk);
        for (int p = 0; p < 3; p++) begin
          pulse_dclk(1'b1);
          check(dout == 1'b0, "R6", "idle output", dout, 0);
        end
        xmit_n = 1'b0;
        @(negedge clk);
      end
      pulse_dclk(i < 8 ? dp[7-i] : 1'b0);
    end
    xmit_n = 1'b1;
    @(negedge clk);
    check(exp_q.size() == 0, "R5", "scoreboard drained", exp_q.size(), 0);
    check(flag == 1'b0, "R9", "no flag while conv quiet", flag, 0);
  endtask

  initial begin : watchdog
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    xmit_n = 1'b0;
    repeat (3) @(negedge clk);
    check(dout == 1'b0, "R1", "dout in reset", dout, 0);
    check(flag == 1'b0, "R1", "flag in reset", flag, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(dout == 1'b0, "R1", "dout after reset", dout, 0);
    check(flag == 1'b0, "R1", "flag after reset", flag, 0);
    xmit_n = 1'b1;
    @(negedge clk);

    transfer(0, 1, 8'hA5, "R2", 1'b0, 1'b0);
    transfer(-4096, 'h0FEFFF, 8'h3C, "R3", 1'b1, 1'b0);
    transfer(-5000, 'h0FEFFE, 8'hC3, "R3", 1'b0, 1'b1);
    transfer(-1048576, 12345, 8'h81, "R2", 1'b1, 1'b0);
    transfer(1048575, -4095, 8'h5A, "R4", 1'b1, 1'b1);

    // R9: dclk three cycles after conv
    conv = ~conv;
    repeat (3) @(negedge clk);
    dclk = ~dclk;
    @(negedge clk);
    check(flag == 1'b1, "R9", "flag dclk after conv", flag, 1);
    @(negedge clk);
    check(flag == 1'b0, "R9", "flag is one cycle", flag, 0);
    repeat (12) @(negedge clk);
    // R9: dclk well outside the window
    conv = ~conv;
    repeat (10) @(negedge clk);
    dclk = ~dclk;
    @(negedge clk);
    check(flag == 1'b0, "R9", "no flag outside window", flag, 0);
    repeat (12) @(negedge clk);
    // R8: conv three cycles after dclk
    dclk = ~dclk;
    repeat (3) @(negedge clk);
    conv = ~conv;
    @(negedge clk);
    check(flag == 1'b1, "R8", "flag conv after dclk", flag, 1);
    repeat (12) @(negedge clk);
    // R8: conv well outside the window
    dclk = ~dclk;
    repeat (10) @(negedge clk);
    conv = ~conv;
    @(negedge clk);
    check(flag == 1'b0, "R8", "no flag outside window", flag, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule